// File: doc/BRIEF.md
# Protected Page Access Checker

This block sits behind a conventional page walk and decides whether a memory access to protected storage may go ahead. It holds one metadata record for each 4 KB page of a contiguous protected frame range. Each record carries a valid flag, a blocked flag, an owner-container tag, a page kind, the linear page the owner must use to reach the frame, and read/write/execute rights. Every request brings the translated frame number, the linear address, the access kind, the rights the page table granted, whether the requester runs in container mode, the active owner tag, and whether the translation came from the translation cache. One cycle later the block answers with allow, a page fault or a general-protection fault, plus an error code.

Rights are combined as an AND of the page-table rights and the record's rights. A page-table refusal is reported first as an ordinary protection fault. Only a refusal by the metadata raises the dedicated map-violation bit (bit 15). A configuration input selects a legacy reporting style, in which map violations become a general-protection fault with a zero code.

A management engine loads records through a write port, and clears single records by writing them with the valid flag low. A flush input drops every valid flag at once. Container-mode accesses to a page whose record is not valid then fault until that record is rewritten. Non-container accesses that land in the protected range are allowed as the page table says, and are also flagged on a separate output, because their effect on protected storage is not defined.

Top module: `spm_gate`

## Requirements
- R1: Every request presented with `req_vld` high is answered exactly one clock later with `rsp_vld` high and exactly one of `rsp_allow`, `rsp_pf`, `rsp_gp` high. Without a request, all response outputs are zero.
- R2: A failed page walk (`req_walk_ok` low) gives `rsp_pf` with no metadata check. The error code has bit 0 clear, bit 15 clear, bit 1 set for a write and bit 4 set for an instruction fetch. Legacy mode does not change this.
- R3: The protected range is frames `BASE_PFN` to `BASE_PFN+NPAGES-1`, and record index = frame − `BASE_PFN`. The linear page compared with a record is `req_laddr[LA_W-1:12]`, so the low 12 address bits never change the result.
- R4: Access kinds are 0 read, 1 write, 2 fetch and 3 read. Rights bits are [0] read, [1] write, [2] execute. When the walk succeeded but the page-table right for the kind is missing, the result is `rsp_pf` with code bit 0 set, bit 15 clear, and bits 1/4 as in R2, whatever the record says.
- R5: A container-mode access inside the range with page-table rights present is allowed only if all of these hold: the record is valid; its owner equals `req_owner`; its kind is regular (0) or thread-control (2), so control (1), version (3) and trim (4) pages deny; its linear page matches; its right for the kind is set; and it is not both blocked and missed in the translation cache (`req_tlb_hit` low). Otherwise the access is a map violation.
- R6: A container-mode access with page-table rights present whose frame lies outside the protected range is a map violation.
- R7: Outside legacy mode, a map violation gives `rsp_pf` with code bit 15 and bit 0 set, and bits 1/4 as in R2.
- R8: With `legacy_gp` high, a map violation gives `rsp_gp` with an all-zero error code.
- R9: A non-container access with page-table rights present is allowed and never sets bit 15. `rsp_undef` is high exactly when such an allowed access lands in the protected range; it is zero for every other response.
- R10: `flush_all` clears every valid flag in one cycle. A record written in the same cycle as a flush keeps the written contents.
- R11: A record write takes effect for requests from the next cycle on. A request presented in the same cycle as a write to its record is judged on the old contents.
- R12: After reset, all response outputs are zero and every record is invalid, so container accesses to the range fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| legacy_gp | input | 1 | Report map violations as general-protection faults with code 0 |
| flush_all | input | 1 | Clear every record's valid flag |
| map_we | input | 1 | Record write strobe |
| map_idx | input | IDX_W | Record index to write |
| map_valid | input | 1 | Written valid flag |
| map_blocked | input | 1 | Written blocked flag |
| map_owner | input | OWN_W | Written owner tag |
| map_type | input | 3 | Written page kind (0 reg, 1 ctrl, 2 thread, 3 version, 4 trim) |
| map_lpage | input | LA_W-12 | Written expected linear page |
| map_perm | input | 3 | Written rights {X,W,R} |
| req_vld | input | 1 | Request present |
| req_walk_ok | input | 1 | Page walk succeeded |
| req_encl | input | 1 | Access made in container mode |
| req_kind | input | 2 | Access kind |
| req_pt_perm | input | 3 | Page-table rights {X,W,R} |
| req_pfn | input | PFN_W | Translated frame number |
| req_laddr | input | LA_W | Linear address |
| req_owner | input | OWN_W | Active owner tag |
| req_tlb_hit | input | 1 | Translation came from the translation cache |
| rsp_vld | output | 1 | Response present |
| rsp_allow | output | 1 | Access permitted |
| rsp_pf | output | 1 | Page fault |
| rsp_gp | output | 1 | General-protection fault |
| rsp_err | output | 16 | Fault error code |
| rsp_undef | output | 1 | Non-container access hit protected range |

## Verification
A record update and a lookup of that same record can fall in one cycle. So can a flush and a record write. The bench provokes both with directed cycles: it rewrites a record while requesting it, and it writes a record while flushing. It also lets random traffic put writes, flushes and requests on shared cycles. The bench judges each response against a reference map. That map is updated only after the expected value for the cycle has been formed, so a same-cycle request must see the old record, and a same-cycle write must survive the flush.

// File: rtl/spm_pkg.sv
package spm_pkg;

  typedef enum logic [2:0] {
    PK_REG   = 3'd0,
    PK_CTRL  = 3'd1,
    PK_THRD  = 3'd2,
    PK_VER   = 3'd3,
    PK_TRIM  = 3'd4
  } page_kind_e;

  localparam int EC_PRESENT = 0;
  localparam int EC_WRITE   = 1;
  localparam int EC_FETCH   = 4;
  localparam int EC_MAPV    = 15;

  // one-hot rights bit needed by an access kind
  function automatic logic [2:0] kind_need(input logic [1:0] kind);
    case (kind)
      2'd1:    return 3'b010;
      2'd2:    return 3'b100;
      default: return 3'b001;
    endcase
  endfunction

  // pages that container code may touch directly
  function automatic logic kind_enterable(input logic [2:0] pk);
    return (pk == PK_REG) || (pk == PK_THRD);
  endfunction

  function automatic logic [15:0] fault_code(input logic [1:0] kind,
                                             input logic present,
                                             input logic mapv);
    logic [15:0] c;
    c = '0;
    c[EC_PRESENT] = present;
    c[EC_WRITE]   = (kind == 2'd1);
    c[EC_FETCH]   = (kind == 2'd2);
    c[EC_MAPV]    = mapv;
    return c;
  endfunction

endpackage

// File: rtl/spm_store.sv
module spm_store #(
  parameter int NPAGES = 16,
  parameter int OWN_W  = 4,
  parameter int LP_W   = 20,
  localparam int IDX_W = $clog2(NPAGES),
  localparam int EW    = 2 + OWN_W + 3 + LP_W + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic             w_valid,
  input  logic             w_blocked,
  input  logic [OWN_W-1:0] w_owner,
  input  logic [2:0]       w_type,
  input  logic [LP_W-1:0]  w_lpage,
  input  logic [2:0]       w_perm,
  input  logic [IDX_W-1:0] ridx,
  output logic             r_valid,
  output logic             r_blocked,
  output logic [OWN_W-1:0] r_owner,
  output logic [2:0]       r_type,
  output logic [LP_W-1:0]  r_lpage,
  output logic [2:0]       r_perm
);

  logic [EW-1:0] wdata;
  logic [EW-1:0] rd_arr [NPAGES];
  logic [EW-1:0] rd;

  assign wdata = {w_valid, w_blocked, w_owner, w_type, w_lpage, w_perm};

  for (genvar i = 0; i < NPAGES; i++) begin : g_ent
    logic [EW-1:0] q;
    logic          hit_w;
    assign hit_w = we && (widx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n)        q <= '0;
      else if (hit_w)    q <= wdata;          // write wins over flush
      else if (flush)    q[EW-1] <= 1'b0;
    end
    assign rd_arr[i] = q;
  end

  assign rd = rd_arr[ridx];
  assign {r_valid, r_blocked, r_owner, r_type, r_lpage, r_perm} = rd;

endmodule

// File: rtl/spm_judge.sv
module spm_judge
  import spm_pkg::*;
#(
  parameter int OWN_W = 4,
  parameter int LP_W  = 20
) (
  input  logic             legacy,
  input  logic             walk_ok,
  input  logic             encl,
  input  logic [1:0]       kind,
  input  logic [2:0]       pt_perm,
  input  logic             in_prot,
  input  logic             tlb_hit,
  input  logic [OWN_W-1:0] owner,
  input  logic [LP_W-1:0]  lpage,
  input  logic             e_valid,
  input  logic             e_blocked,
  input  logic [OWN_W-1:0] e_owner,
  input  logic [2:0]       e_type,
  input  logic [LP_W-1:0]  e_lpage,
  input  logic [2:0]       e_perm,
  output logic             allow,
  output logic             pf,
  output logic             gp,
  output logic             undef,
  output logic [15:0]      err,
  output logic             walk_fail,
  output logic             pt_deny,
  output logic             map_viol
);

  logic [2:0] need;
  logic       ent_ok;

  always_comb begin
    need      = kind_need(kind);
    walk_fail = !walk_ok;
    pt_deny   = walk_ok && ((pt_perm & need) == 3'b000);
    ent_ok    = in_prot && e_valid && (e_owner == owner) &&
                kind_enterable(e_type) && (e_lpage == lpage) &&
                ((e_perm & need) != 3'b000) && !(e_blocked && !tlb_hit);
    map_viol  = encl && walk_ok && !pt_deny && !ent_ok;
    allow     = walk_ok && !pt_deny && !map_viol;
    pf        = walk_fail || pt_deny || (map_viol && !legacy);
    gp        = map_viol && legacy;
    undef     = allow && !encl && in_prot;
    if (walk_fail)                  err = fault_code(kind, 1'b0, 1'b0);
    else if (pt_deny)               err = fault_code(kind, 1'b1, 1'b0);
    else if (map_viol && !legacy)   err = fault_code(kind, 1'b1, 1'b1);
    else                            err = '0;
  end

endmodule

// File: rtl/spm_gate.sv
module spm_gate #(
  parameter int NPAGES   = 16,
  parameter int OWN_W    = 4,
  parameter int PFN_W    = 20,
  parameter int LA_W     = 32,
  parameter int BASE_PFN = 'h80000,
  localparam int IDX_W   = $clog2(NPAGES),
  localparam int LP_W    = LA_W - 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             legacy_gp,
  input  logic             flush_all,
  input  logic             map_we,
  input  logic [IDX_W-1:0] map_idx,
  input  logic             map_valid,
  input  logic             map_blocked,
  input  logic [OWN_W-1:0] map_owner,
  input  logic [2:0]       map_type,
  input  logic [LP_W-1:0]  map_lpage,
  input  logic [2:0]       map_perm,
  input  logic             req_vld,
  input  logic             req_walk_ok,
  input  logic             req_encl,
  input  logic [1:0]       req_kind,
  input  logic [2:0]       req_pt_perm,
  input  logic [PFN_W-1:0] req_pfn,
  input  logic [LA_W-1:0]  req_laddr,
  input  logic [OWN_W-1:0] req_owner,
  input  logic             req_tlb_hit,
  output logic             rsp_vld,
  output logic             rsp_allow,
  output logic             rsp_pf,
  output logic             rsp_gp,
  output logic [15:0]      rsp_err,
  output logic             rsp_undef
);

  localparam logic [PFN_W-1:0] BASE_LO = PFN_W'(BASE_PFN);

  // named internal events (observed by the checker)
  logic             hit_prot;
  logic             ev_walk_fail;
  logic             ev_pt_deny;
  logic             ev_map_viol;

  logic [PFN_W-1:0] off;
  logic             e_valid, e_blocked;
  logic [OWN_W-1:0] e_owner;
  logic [2:0]       e_type, e_perm;
  logic [LP_W-1:0]  e_lpage;
  logic             j_allow, j_pf, j_gp, j_undef;
  logic [15:0]      j_err;
  logic             unused_bits;

  assign off         = req_pfn - BASE_LO;
  assign hit_prot    = (req_pfn >= BASE_LO) && (off < PFN_W'(NPAGES));
  assign unused_bits = ^{req_laddr[11:0], off[PFN_W-1:IDX_W]};

  spm_store #(.NPAGES(NPAGES), .OWN_W(OWN_W), .LP_W(LP_W)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush_all), .we(map_we), .widx(map_idx),
    .w_valid(map_valid), .w_blocked(map_blocked), .w_owner(map_owner),
    .w_type(map_type), .w_lpage(map_lpage), .w_perm(map_perm),
    .ridx(off[IDX_W-1:0]),
    .r_valid(e_valid), .r_blocked(e_blocked), .r_owner(e_owner),
    .r_type(e_type), .r_lpage(e_lpage), .r_perm(e_perm)
  );

  spm_judge #(.OWN_W(OWN_W), .LP_W(LP_W)) u_judge (
    .legacy(legacy_gp), .walk_ok(req_walk_ok), .encl(req_encl),
    .kind(req_kind), .pt_perm(req_pt_perm), .in_prot(hit_prot),
    .tlb_hit(req_tlb_hit), .owner(req_owner), .lpage(req_laddr[LA_W-1:12]),
    .e_valid(e_valid), .e_blocked(e_blocked), .e_owner(e_owner),
    .e_type(e_type), .e_lpage(e_lpage), .e_perm(e_perm),
    .allow(j_allow), .pf(j_pf), .gp(j_gp), .undef(j_undef), .err(j_err),
    .walk_fail(ev_walk_fail), .pt_deny(ev_pt_deny), .map_viol(ev_map_viol)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_vld   <= 1'b0;
      rsp_allow <= 1'b0;
      rsp_pf    <= 1'b0;
      rsp_gp    <= 1'b0;
      rsp_err   <= '0;
      rsp_undef <= 1'b0;
    end else begin
      rsp_vld   <= req_vld;
      rsp_allow <= req_vld && j_allow;
      rsp_pf    <= req_vld && j_pf;
      rsp_gp    <= req_vld && j_gp;
      rsp_err   <= req_vld ? j_err : 16'h0000;
      rsp_undef <= req_vld && j_undef;
    end
  end

endmodule

// File: rtl/spm_gate_chk.sv
module spm_gate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        legacy_gp,
  input logic        flush_all,
  input logic        map_we,
  input logic        req_vld,
  input logic        req_walk_ok,
  input logic        req_encl,
  input logic        hit_prot,
  input logic        ev_map_viol,
  input logic        rsp_vld,
  input logic        rsp_allow,
  input logic        rsp_pf,
  input logic        rsp_gp,
  input logic [15:0] rsp_err,
  input logic        rsp_undef
);

  // R1
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> rsp_vld && ($countones({rsp_allow, rsp_pf, rsp_gp}) == 1));

  // R1
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> !rsp_allow && !rsp_pf && !rsp_gp && (rsp_err == 16'h0000));

  // R2
  walk_fail_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !req_walk_ok) |=> rsp_pf && !rsp_err[15] && !rsp_err[0]);

  // R7
  map_viol_pf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && ev_map_viol && !legacy_gp) |=> rsp_pf && rsp_err[15] && rsp_err[0]);

  // R8
  map_viol_gp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && ev_map_viol && legacy_gp) |=> rsp_gp && (rsp_err == 16'h0000));

  // R9
  host_no_mapbit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !req_encl) |=> !rsp_err[15] && !rsp_gp);

  // R9
  undef_only_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && (req_encl || !hit_prot)) |=> !rsp_undef);

  // R10
  flush_denies_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all && !map_we) ##1 (req_vld && req_encl && hit_prot) |=> !rsp_allow);

endmodule

bind spm_gate spm_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .legacy_gp(legacy_gp), .flush_all(flush_all),
  .map_we(map_we), .req_vld(req_vld), .req_walk_ok(req_walk_ok),
  .req_encl(req_encl), .hit_prot(hit_prot), .ev_map_viol(ev_map_viol),
  .rsp_vld(rsp_vld), .rsp_allow(rsp_allow), .rsp_pf(rsp_pf), .rsp_gp(rsp_gp),
  .rsp_err(rsp_err), .rsp_undef(rsp_undef)
);

// File: tb/spm_gate_test.sv
module spm_gate_test;

  localparam int NP    = 16;
  localparam int OW    = 4;
  localparam int PW    = 20;
  localparam int LW    = 32;
  localparam int BASE  = 'h80000;
  localparam int IW    = $clog2(NP);
  localparam int LPW   = LW - 12;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           legacy_gp = 1'b0, flush_all = 1'b0, map_we = 1'b0;
  logic [IW-1:0]  map_idx = '0;
  logic           map_valid = 1'b0, map_blocked = 1'b0;
  logic [OW-1:0]  map_owner = '0;
  logic [2:0]     map_type = '0, map_perm = '0;
  logic [LPW-1:0] map_lpage = '0;
  logic           req_vld = 1'b0, req_walk_ok = 1'b0, req_encl = 1'b0, req_tlb_hit = 1'b0;
  logic [1:0]     req_kind = '0;
  logic [2:0]     req_pt_perm = '0;
  logic [PW-1:0]  req_pfn = '0;
  logic [LW-1:0]  req_laddr = '0;
  logic [OW-1:0]  req_owner = '0;
  logic           rsp_vld, rsp_allow, rsp_pf, rsp_gp, rsp_undef;
  logic [15:0]    rsp_err;

  spm_gate #(.NPAGES(NP), .OWN_W(OW), .PFN_W(PW), .LA_W(LW), .BASE_PFN(BASE)) uut (
    .clk(clk), .rst_n(rst_n), .legacy_gp(legacy_gp), .flush_all(flush_all),
    .map_we(map_we), .map_idx(map_idx), .map_valid(map_valid),
    .map_blocked(map_blocked), .map_owner(map_owner), .map_type(map_type),
    .map_lpage(map_lpage), .map_perm(map_perm), .req_vld(req_vld),
    .req_walk_ok(req_walk_ok), .req_encl(req_encl), .req_kind(req_kind),
    .req_pt_perm(req_pt_perm), .req_pfn(req_pfn), .req_laddr(req_laddr),
    .req_owner(req_owner), .req_tlb_hit(req_tlb_hit), .rsp_vld(rsp_vld),
    .rsp_allow(rsp_allow), .rsp_pf(rsp_pf), .rsp_gp(rsp_gp),
    .rsp_err(rsp_err), .rsp_undef(rsp_undef)
  );

  always #10 clk = ~clk;   // 50 MHz

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  // reference map
  bit           m_v   [NP];
  bit           m_b   [NP];
  bit [OW-1:0]  m_o   [NP];
  bit [2:0]     m_t   [NP];
  bit [LPW-1:0] m_l   [NP];
  bit [2:0]     m_p   [NP];

  // expected response
  bit        x_vld, x_allow, x_pf, x_gp, x_undef;
  bit [15:0] x_err;
  string     x_tag;

  function automatic bit [15:0] code_of(input bit [1:0] k, input bit p, input bit m);
    return {m, 10'd0, (k == 2'd2), 2'b00, (k == 2'd1), p};
  endfunction

  task automatic predict();
    int  bitn;
    bit  inr;
    int  ix;
    bit  good;
    x_vld = req_vld; x_allow = 0; x_pf = 0; x_gp = 0; x_undef = 0; x_err = 0; x_tag = "R1";
    if (!req_vld) return;
    bitn = (req_kind == 2'd1) ? 1 : (req_kind == 2'd2) ? 2 : 0;
    inr  = (int'(req_pfn) >= BASE) && (int'(req_pfn) < BASE + NP);
    ix   = int'(req_pfn) - BASE;
    if (!req_walk_ok) begin
      x_pf = 1; x_err = code_of(req_kind, 0, 0); x_tag = "R2";
    end else if (!req_pt_perm[bitn]) begin
      x_pf = 1; x_err = code_of(req_kind, 1, 0); x_tag = "R4";
    end else if (!req_encl) begin
      x_allow = 1; x_undef = inr; x_tag = "R9";
    end else begin
      good = 0;
      if (inr) begin
        good = m_v[ix] && (m_o[ix] == req_owner) && (m_t[ix] == 3'd0 || m_t[ix] == 3'd2)
               && (m_l[ix] == req_laddr[LW-1:12]) && m_p[ix][bitn]
               && !(m_b[ix] && !req_tlb_hit);
      end
      if (good) begin
        x_allow = 1; x_tag = "R5 R3";
      end else if (legacy_gp) begin
        x_gp = 1; x_tag = inr ? "R8 R5" : "R8 R6";
      end else begin
        x_pf = 1; x_err = code_of(req_kind, 1, 1); x_tag = inr ? "R7 R5" : "R7 R6";
      end
    end
  endtask

  task automatic model_update(input bit fl, input bit we, input int ix, input bit v,
                              input bit b, input bit [OW-1:0] o, input bit [2:0] t,
                              input bit [LPW-1:0] l, input bit [2:0] p);
    if (fl) for (int i = 0; i < NP; i++) m_v[i] = 0;
    if (we) begin m_v[ix] = v; m_b[ix] = b; m_o[ix] = o; m_t[ix] = t; m_l[ix] = l; m_p[ix] = p; end
  endtask

  task automatic check(input string tag, input bit [20:0] act, input bit [20:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one cycle: inputs already driven (at negedge)
  task automatic step(input string note);
    bit fl, we; int ix; bit v, b; bit [OW-1:0] o; bit [2:0] t, p; bit [LPW-1:0] l;
    predict();
    fl = flush_all; we = map_we; ix = int'(map_idx); v = map_valid; b = map_blocked;
    o = map_owner; t = map_type; l = map_lpage; p = map_perm;
    @(posedge clk);
    model_update(fl, we, ix, v, b, o, t, l, p);
    @(negedge clk);
    // R1: valid and single outcome
    check({"R1 ", note}, {20'd0, rsp_vld}, {20'd0, x_vld});
    check({x_tag, " ", note}, {rsp_allow, rsp_pf, rsp_gp, rsp_undef, 1'b0, rsp_err},
          {x_allow, x_pf, x_gp, x_undef, 1'b0, x_err});
    map_we = 0; flush_all = 0; req_vld = 0;
  endtask

  task automatic wr(input int ix, input bit v, input bit b, input int o, input int t,
                    input int lp, input int p);
    map_we = 1; map_idx = IW'(ix); map_valid = v; map_blocked = b;
    map_owner = OW'(o); map_type = 3'(t); map_lpage = LPW'(lp); map_perm = 3'(p);
  endtask

  task automatic rq(input bit en, input bit wk, input int k, input int pt, input int pfn,
                    input logic [LW-1:0] la, input int o, input bit th);
    req_vld = 1; req_encl = en; req_walk_ok = wk; req_kind = 2'(k); req_pt_perm = 3'(pt);
    req_pfn = PW'(pfn); req_laddr = la; req_owner = OW'(o); req_tlb_hit = th;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    for (int i = 0; i < NP; i++) begin m_v[i] = 0; m_b[i] = 0; m_o[i] = 0; m_t[i] = 0; m_l[i] = 0; m_p[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12: reset outputs
    check("R12 reset", {rsp_vld, rsp_allow, rsp_pf, rsp_gp, rsp_undef, rsp_err}, 21'd0);
    rst_n = 1;
    // R12: empty map denies
    rq(1, 1, 0, 7, BASE, 32'h12345000, 3, 1); step("R12 empty map");
    wr(0, 1, 0, 3, 0, 'h12345, 3'b011); step("load0");
    rq(1, 1, 0, 7, BASE, 32'h12345abc, 3, 1); step("R5 read ok, R3 low bits");
    rq(1, 1, 1, 7, BASE, 32'h12345fff, 3, 0); step("R5 write ok");
    rq(1, 1, 2, 7, BASE, 32'h12345000, 3, 1); step("R7 fetch no X");
    rq(1, 1, 1, 3'b001, BASE, 32'h12345000, 3, 1); step("R4 pt deny");
    rq(1, 1, 0, 7, BASE, 32'h12345000, 4, 1); step("R5 owner mismatch");
    rq(1, 1, 0, 7, BASE, 32'h12346000, 3, 1); step("R3 lpage mismatch");
    wr(1, 1, 1, 3, 2, 'h00100, 3'b111); step("load1");
    rq(1, 1, 2, 7, BASE + 1, 32'h00100000, 3, 1); step("R5 blocked tlb hit");
    rq(1, 1, 2, 7, BASE + 1, 32'h00100000, 3, 0); step("R5 blocked tlb miss");
    wr(2, 1, 0, 3, 4, 'h00200, 3'b111); step("load2 trim");
    rq(1, 1, 0, 7, BASE + 2, 32'h00200000, 3, 1); step("R5 trim denied");
    wr(3, 1, 0, 3, 3, 'h00300, 3'b111); step("load3 ver");
    rq(1, 1, 0, 7, BASE + 3, 32'h00300000, 3, 1); step("R5 version denied");
    rq(1, 1, 0, 7, BASE + NP, 32'h12345000, 3, 1); step("R6 outside");
    rq(1, 1, 0, 7, BASE - 1, 32'h12345000, 3, 1); step("R6 below base");
    legacy_gp = 1;
    rq(1, 1, 2, 7, BASE, 32'h12345000, 3, 1); step("R8 legacy gp");
    rq(1, 0, 1, 7, BASE, 32'h12345000, 3, 1); step("R2 walk fail legacy");
    legacy_gp = 0;
    rq(1, 0, 2, 7, BASE + 5, 32'h0, 3, 1); step("R2 walk fail fetch");
    rq(0, 1, 1, 7, BASE + 4, 32'h0, 9, 0); step("R9 host in range");
    rq(0, 1, 0, 7, 'h00010, 32'h0, 9, 0); step("R9 host outside");
    rq(0, 1, 1, 3'b101, BASE, 32'h0, 9, 0); step("R4 host pt deny");
    // R11: write and request to same record in one cycle
    wr(0, 1, 0, 3, 0, 'h12345, 3'b000);
    rq(1, 1, 0, 7, BASE, 32'h12345000, 3, 1); step("R11 old contents");
    rq(1, 1, 0, 7, BASE, 32'h12345000, 3, 1); step("R11 new contents");
    // R10: flush and write in one cycle
    wr(5, 1, 0, 6, 2, 'h00500, 3'b001); flush_all = 1; step("R10 flush+write");
    rq(1, 1, 0, 7, BASE + 1, 32'h00100000, 3, 1); step("R10 flushed entry");
    rq(1, 1, 0, 7, BASE + 5, 32'h00500000, 6, 1); step("R10 survivor");

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      int ix;
      ix = int'($urandom_range(NP - 1));
      if ($urandom_range(99) < 10) begin
        wr(int'($urandom_range(NP - 1)), $urandom_range(99) < 85, $urandom_range(99) < 20,
           int'($urandom_range(3)), ($urandom_range(99) < 70) ? 2 * int'($urandom_range(1)) : int'($urandom_range(4)),
           int'($urandom_range(7)), int'($urandom_range(7)));
      end
      if ($urandom_range(99) < 2) flush_all = 1;
      if ($urandom_range(99) < 3) legacy_gp = ~legacy_gp;
      if ($urandom_range(99) < 85) begin
        rq($urandom_range(99) < 75, $urandom_range(99) < 92, int'($urandom_range(3)),
           ($urandom_range(99) < 80) ? 7 : int'($urandom_range(7)),
           ($urandom_range(99) < 85) ? BASE + ix : int'($urandom_range(32'hFFFFF)),
           {($urandom_range(99) < 80) ? m_l[ix] : LPW'($urandom_range(7)), 12'($urandom)},
           ($urandom_range(99) < 80) ? int'(m_o[ix]) : int'($urandom_range(3)),
           $urandom_range(1) == 1);
      end
      step("random");
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule